// File: doc/BRIEF.md
# Integer ALU with Flag Register and Skip-Condition Evaluator

This block is the integer execution unit of a 32-bit processor core. One combinational path takes two operands and an operation code. It returns the result, whether that result is to be written back, and the seven status flags the operation produces. The flags go into a register that holds them until the next arithmetic-class operation is strobed. Addition, subtraction, multiplication, the three bitwise operations, both shifts and compare use this path.

A second, independent combinational port decides conditional skips against the registered flags. The caller gives it either one flag index with a polarity, or two flag indices with a two-flag predicate code. It answers whether the following instruction should execute. When an index or a predicate code is invalid, it raises an exception code and suppresses execution. The caller advances the program counter by an extra 4 when the answer is "do not run".

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is a combinational function of `op_code`, `opnd_a` and `opnd_b`, whatever the value of `op_valid`. The codes are 0 add, 1 subtract (a-b), 2 multiply (low 32 bits of the product), 3 AND, 4 OR, 5 XOR, 6 shift left, 7 logical shift right and 8 compare, which gives a-b. Shifts use only bits 4:0 of `opnd_b`. Codes 9 to 15 give a zero result.
- R2: `result_we` is 1 only when `op_valid` is 1 and `op_code` is 0 to 7. It is 0 for compare (8), for codes 9 to 15, and whenever `op_valid` is 0.
- R3: The `flags` word has zero at bit 31, carry at bit 30, overflow at bit 29, sign at bit 28, even at bit 27, zero-upper at bit 26 and zero-lower at bit 25. Bits 24:0 are always 0. Zero means the result is 0. Sign copies result bit 31. Even means result bit 0 is 0. Zero-upper means the result is below 2^16. Zero-lower means result bits 15:0 are all 0.
- R4: For add, carry is the unsigned carry out of bit 31. For subtract and compare, carry means a borrow (`opnd_a` is unsigned-less than `opnd_b`). For both, overflow means the signed result does not fit in 32 bits.
- R5: For multiply, carry is set when the upper 32 bits of the unsigned 64-bit product are non-zero. Overflow is set when the signed 64-bit product is not the sign extension of its low 32 bits.
- R6: AND, OR, XOR and both shifts clear carry and overflow.
- R7: `flags` takes the new flags at the clock edge only when `op_valid` is 1 and `op_code` is 0 to 8. Otherwise it holds its value. A synchronous `rst` clears it to 0 and takes priority over an update.
- R8: Single-flag mode (`cond_pair` = 0): index k in `cond_idx_a` selects `flags` bit 31-k (0 zero, 1 carry, 2 overflow, 3 sign, 4 even, 5 zero-upper, 6 zero-lower). With `cond_neg` = 0, `cond_run` is 1 when that flag is set. With `cond_neg` = 1, `cond_run` is 1 when it is clear.
- R9: Two-flag mode (`cond_pair` = 1): with A the flag chosen by `cond_idx_a` and B the flag chosen by `cond_idx_b`, `cond_code` selects the predicate for `cond_run`. The codes are 1 A|B, 2 A&B, 3 A^B, 4 neither, 5 not both, 6 A and not B, 7 B and not A.
- R10: An index above 6 raises `cond_exc` with `cond_exc_code` 0x0C and forces `cond_run` to 0. In single-flag mode only `cond_idx_a` is checked, so `cond_idx_b` and `cond_code` have no effect.
- R11: In two-flag mode a code outside 1 to 7 raises 0x0D with `cond_run` 0. An index error takes priority over a code error. Without an exception `cond_exc_code` is 0x00.
- R12: The condition port reads the registered flags, so an operation strobed in one cycle affects `cond_run` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe for the operation on `op_code` |
| op_code | input | 4 | Operation select (0 add … 8 compare) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result is to be written back |
| flags | output | 32 | Registered flags word |
| cond_pair | input | 1 | 1 selects two-flag mode |
| cond_neg | input | 1 | Single-flag polarity, 1 runs on clear |
| cond_idx_a | input | 8 | First flag index |
| cond_idx_b | input | 8 | Second flag index |
| cond_code | input | 8 | Two-flag predicate code |
| cond_run | output | 1 | Next instruction executes |
| cond_exc | output | 1 | Condition request is invalid |
| cond_exc_code | output | 8 | 0x0C bad index, 0x0D bad code, else 0x00 |

## Verification
The bench builds the block with its default 32-bit datapath, because that is the width the flag layout and exception codes are defined for. At this width the signed and unsigned wrap points are within reach of single operations: 0x7FFFFFFF+1, 0xFFFFFFFF+1, products that cross 2^32, and results either side of 2^16 for the zero-upper flag. Shift amounts above 31 show that only the low five bits count. Predicate codes 0, 8 and above, and indices 7 and higher, are driven alongside valid ones, including both errors at once, to check the priority between the two exception codes.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int NUM_FLAGS = 7;
    localparam int OP_W      = 4;
    localparam int SEL_W     = 8;
    localparam int COND_W    = 8;
    localparam int EXC_W     = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_CMP = 4'd8
    } alu_op_e;

    // Packed most significant first: zero lands on the top bit of the word.
    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
        logic sign;
        logic even;
        logic zup;
        logic zlo;
    } flag_set_t;

    typedef enum logic [COND_W-1:0] {
        PAIR_ANY     = 8'd1,
        PAIR_BOTH    = 8'd2,
        PAIR_ONE     = 8'd3,
        PAIR_NONE    = 8'd4,
        PAIR_NOTBOTH = 8'd5,
        PAIR_AONLY   = 8'd6,
        PAIR_BONLY   = 8'd7
    } pair_cond_e;

    localparam logic [EXC_W-1:0] EXC_NONE      = 8'h00;
    localparam logic [EXC_W-1:0] EXC_FLAG_IDX  = 8'h0C;
    localparam logic [EXC_W-1:0] EXC_COND_CODE = 8'h0D;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_CMP;
    endfunction

    function automatic logic op_writes(input logic [OP_W-1:0] op);
        return op_known(op) && (op != OP_CMP);
    endfunction

    function automatic logic code_legal(input logic [COND_W-1:0] code);
        return (code >= PAIR_ANY) && (code <= PAIR_BONLY);
    endfunction

    function automatic logic pair_eval(input logic [COND_W-1:0] code,
                                       input logic fa, input logic fb);
        logic hit;
        case (pair_cond_e'(code))
            PAIR_ANY:     hit = fa | fb;
            PAIR_BOTH:    hit = fa & fb;
            PAIR_ONE:     hit = fa ^ fb;
            PAIR_NONE:    hit = ~(fa | fb);
            PAIR_NOTBOTH: hit = ~(fa & fb);
            PAIR_AONLY:   hit = fa & ~fb;
            PAIR_BONLY:   hit = fb & ~fa;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output flag_set_t         flags_nx
);

    localparam int MSB    = DATA_W - 1;
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W:0]          sum_w;
    logic [DATA_W:0]          dif_w;
    logic [PROD_W-1:0]        prod_u;
    logic signed [PROD_W-1:0] prod_s;
    logic                     add_ovf;
    logic                     sub_ovf;
    logic                     mul_cry;
    logic                     mul_ovf;
    logic                     cry;
    logic                     ovf;
    logic [SH_W-1:0]          sh_amt;

    assign sum_w  = {1'b0, a} + {1'b0, b};
    assign dif_w  = {1'b0, a} - {1'b0, b};
    assign prod_u = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    assign prod_s = $signed({{DATA_W{a[MSB]}}, a}) * $signed({{DATA_W{b[MSB]}}, b});
    assign sh_amt = b[SH_W-1:0];

    assign add_ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
    assign sub_ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
    assign mul_cry = |prod_u[PROD_W-1:DATA_W];
    assign mul_ovf = prod_s != {{DATA_W{prod_s[MSB]}}, prod_s[MSB:0]};

    always_comb begin
        result = '0;
        cry    = 1'b0;
        ovf    = 1'b0;
        case (alu_op_e'(op))
            OP_ADD: begin
                result = sum_w[MSB:0];
                cry    = sum_w[DATA_W];
                ovf    = add_ovf;
            end
            OP_SUB, OP_CMP: begin
                result = dif_w[MSB:0];
                cry    = dif_w[DATA_W];
                ovf    = sub_ovf;
            end
            OP_MUL: begin
                result = prod_u[MSB:0];
                cry    = mul_cry;
                ovf    = mul_ovf;
            end
            OP_AND: result = a & b;
            OP_OR:  result = a | b;
            OP_XOR: result = a ^ b;
            OP_SHL: result = a << sh_amt;
            OP_SHR: result = a >> sh_amt;
            default: result = '0;
        endcase
    end

    always_comb begin
        flags_nx.zero  = (result == '0);
        flags_nx.carry = cry;
        flags_nx.ovf   = ovf;
        flags_nx.sign  = result[MSB];
        flags_nx.even  = ~result[0];
        flags_nx.zup   = (result[MSB:HALF_W] == '0);
        flags_nx.zlo   = (result[HALF_W-1:0] == '0);
    end

endmodule

// File: rtl/flag_store.sv
module flag_store
    import alu_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd,
    input  flag_set_t flags_nx,
    output flag_set_t flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (upd) begin
            flags_q <= flags_nx;
        end
    end

endmodule

// File: rtl/flag_cond.sv
module flag_cond
    import alu_flag_pkg::*;
(
    input  flag_set_t          flags_q,
    input  logic               pair,
    input  logic               neg,
    input  logic [SEL_W-1:0]   idx_a,
    input  logic [SEL_W-1:0]   idx_b,
    input  logic [COND_W-1:0]  code,
    output logic               run,
    output logic               exc,
    output logic [EXC_W-1:0]   exc_code
);

    localparam int PICK_W = $clog2(NUM_FLAGS);
    localparam int PICK_N = 1 << PICK_W;

    logic [PICK_N-1:0] fvec;
    logic              ok_a;
    logic              ok_b;
    logic              fa;
    logic              fb;
    logic              idx_bad;
    logic              code_bad;

    // Index 0 is the most significant flag of the packed set.
    for (genvar g = 0; g < PICK_N; g++) begin : g_pick
        if (g < NUM_FLAGS) begin : g_real
            assign fvec[g] = flags_q[NUM_FLAGS-1-g];
        end else begin : g_pad
            assign fvec[g] = 1'b0;
        end
    end

    assign ok_a = idx_a < SEL_W'(NUM_FLAGS);
    assign ok_b = idx_b < SEL_W'(NUM_FLAGS);
    assign fa   = fvec[idx_a[PICK_W-1:0]];
    assign fb   = fvec[idx_b[PICK_W-1:0]];

    assign idx_bad  = pair ? !(ok_a && ok_b) : !ok_a;
    assign code_bad = pair && !code_legal(code);

    always_comb begin
        exc      = idx_bad || code_bad;
        exc_code = EXC_NONE;
        if (idx_bad) begin
            exc_code = EXC_FLAG_IDX;
        end else if (code_bad) begin
            exc_code = EXC_COND_CODE;
        end
        if (exc) begin
            run = 1'b0;
        end else if (pair) begin
            run = pair_eval(code, fa, fb);
        end else begin
            run = fa ^ neg;
        end
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_code,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [DATA_W-1:0]   flags,
    input  logic                cond_pair,
    input  logic                cond_neg,
    input  logic [SEL_W-1:0]    cond_idx_a,
    input  logic [SEL_W-1:0]    cond_idx_b,
    input  logic [COND_W-1:0]   cond_code,
    output logic                cond_run,
    output logic                cond_exc,
    output logic [EXC_W-1:0]    cond_exc_code
);

    localparam int PAD_W = DATA_W - NUM_FLAGS;

    flag_set_t flags_nx;
    flag_set_t flags_q;
    logic      flag_upd;

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op       (op_code),
        .a        (opnd_a),
        .b        (opnd_b),
        .result   (result),
        .flags_nx (flags_nx)
    );

    assign flag_upd  = op_valid && op_known(op_code);
    assign result_we = op_valid && op_writes(op_code);

    flag_store u_fs (
        .clk      (clk),
        .rst      (rst),
        .upd      (flag_upd),
        .flags_nx (flags_nx),
        .flags_q  (flags_q)
    );

    assign flags = {flags_q, {PAD_W{1'b0}}};

    flag_cond u_fc (
        .flags_q  (flags_q),
        .pair     (cond_pair),
        .neg      (cond_neg),
        .idx_a    (cond_idx_a),
        .idx_b    (cond_idx_b),
        .code     (cond_code),
        .run      (cond_run),
        .exc      (cond_exc),
        .exc_code (cond_exc_code)
    );

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic [DATA_W-1:0] flags,
    input logic              cond_run,
    input logic              cond_exc,
    input logic [7:0]        cond_exc_code
);

    localparam int MSB = DATA_W - 1;

    logic strobe_known;
    assign strobe_known = op_valid && (op_code <= 4'd8);

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd8) |-> !result_we);                          // R2

    AST_PAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flags[MSB-7:0] == '0);                                                  // R3

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        strobe_known |=> (flags[MSB] == ($past(result) == '0)));                // R3

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd1) |=> (flags[MSB-1] == ($past(opnd_a) < $past(opnd_b)))); // R4

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 4'd3 && op_code <= 4'd7) |=> (flags[MSB-1:MSB-2] == 2'b00)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !strobe_known |=> $stable(flags));                                      // R7

    AST_EXC_BLOCKS_RUN: assert property (@(posedge clk) disable iff (rst)
        cond_exc |-> !cond_run);                                                // R10

    AST_EXC_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cond_exc |-> (cond_exc_code == 8'h0C || cond_exc_code == 8'h0D));      // R11

    AST_NO_EXC_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cond_exc |-> (cond_exc_code == 8'h00));                                // R11

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .result        (result),
    .result_we     (result_we),
    .flags         (flags),
    .cond_run      (cond_run),
    .cond_exc      (cond_exc),
    .cond_exc_code (cond_exc_code)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        result_we;
    logic [31:0] flags;
    logic        cond_pair = 1'b0;
    logic        cond_neg = 1'b0;
    logic [7:0]  cond_idx_a = '0;
    logic [7:0]  cond_idx_b = '0;
    logic [7:0]  cond_code = '0;
    logic        cond_run;
    logic        cond_exc;
    logic [7:0]  cond_exc_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu_flag_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .result_we(result_we),
        .flags(flags), .cond_pair(cond_pair), .cond_neg(cond_neg),
        .cond_idx_a(cond_idx_a), .cond_idx_b(cond_idx_b), .cond_code(cond_code),
        .cond_run(cond_run), .cond_exc(cond_exc), .cond_exc_code(cond_exc_code)
    );

    typedef struct {
        string       tag;
        string       ctag;
        logic [31:0] res;
        logic        we;
        logic [31:0] flg;
        logic        run;
        logic        exc;
        logic [7:0]  code;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] model_flags = '0;

    function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, output logic [31:0] fw);
        logic [31:0] r;
        logic [63:0] wide;
        longint      sa, sb, ss;
        logic        c, v;
        sa = $signed(a);
        sb = $signed(b);
        ss = 0;
        c = 0;
        v = 0;
        case (op)
            4'd0: begin
                wide = {32'b0, a} + {32'b0, b};
                r = wide[31:0]; c = wide[32]; ss = sa + sb;
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
            4'd1, 4'd8: begin
                r = a - b; c = (a < b); ss = sa - sb;
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
            4'd2: begin
                wide = {32'b0, a} * {32'b0, b};
                r = wide[31:0]; c = (wide[63:32] != 0); ss = sa * sb;
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6: r = a << b[4:0];
            4'd7: r = a >> b[4:0];
            default: r = 32'd0;
        endcase
        fw = {(r == 0), c, v, r[31], ~r[0], (r < 32'h10000), (r[15:0] == 0), 25'd0};
        return r;
    endfunction

    task automatic ref_cond(input logic [31:0] fw, input bit pair, input bit neg,
                            input logic [7:0] ia, input logic [7:0] ib, input logic [7:0] cc,
                            output logic run, output logic exc, output logic [7:0] code);
        bit fa, fb, bad_i, bad_c;
        fa = (ia < 7) ? fw[31 - ia] : 1'b0;
        fb = (ib < 7) ? fw[31 - ib] : 1'b0;
        bad_i = pair ? (ia > 6 || ib > 6) : (ia > 6);
        bad_c = pair && (cc < 1 || cc > 7);
        exc = bad_i || bad_c;
        code = bad_i ? 8'h0C : (bad_c ? 8'h0D : 8'h00);
        run = 0;
        if (!exc) begin
            if (!pair) run = fa ^ neg;
            else case (cc)
                8'd1: run = fa | fb;
                8'd2: run = fa & fb;
                8'd3: run = fa ^ fb;
                8'd4: run = !(fa | fb);
                8'd5: run = !(fa & fb);
                8'd6: run = fa & !fb;
                default: run = fb & !fa;
            endcase
        end
    endtask

    task automatic drive(input string tag, input bit v, input logic [3:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input string ctag, input bit pair, input bit neg,
                         input logic [7:0] ia, input logic [7:0] ib, input logic [7:0] cc,
                         input bit do_rst = 0);
        exp_t        e;
        logic [31:0] nf;
        @(posedge clk);
        #1;
        rst = do_rst; op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
        cond_pair = pair; cond_neg = neg; cond_idx_a = ia; cond_idx_b = ib; cond_code = cc;
        e.tag  = tag;
        e.ctag = ctag;
        e.res  = ref_op(op, a, b, nf);
        e.we   = v && (op <= 4'd7);
        e.flg  = model_flags;
        ref_cond(model_flags, pair, neg, ia, ib, cc, e.run, e.exc, e.code);
        sbq.push_back(e);
        if (do_rst) model_flags = '0;
        else if (v && op <= 4'd8) model_flags = nf;
    endtask

    task automatic cmp(input string what, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: half a period after each drive, compare against the queued item.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp("result",    e.tag,  result,              e.res);
                cmp("result_we", e.tag,  {31'd0, result_we},  {31'd0, e.we});
                cmp("flags",     e.tag,  flags,               e.flg);
                cmp("cond_run",  e.ctag, {31'd0, cond_run},   {31'd0, e.run});
                cmp("cond_exc",  e.ctag, {31'd0, cond_exc},   {31'd0, e.exc});
                cmp("exc_code",  e.ctag, {24'd0, cond_exc_code}, {24'd0, e.code});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R7 reset state, R8 zero flag clear after reset
        drive("R7", 0, 4'd0, 32'd0, 32'd0, "R8", 0, 0, 8'd0, 8'd0, 8'd0);
        // R1 R3 plain add, zero-upper set, zero-lower clear
        drive("R3", 1, 4'd0, 32'd5, 32'd7, "R8", 0, 1, 8'd0, 8'd0, 8'd0);
        // R12 flags of the add visible now: even set
        drive("R4", 1, 4'd0, 32'hFFFF_FFFF, 32'd1, "R12", 0, 0, 8'd4, 8'd0, 8'd0);
        drive("R4", 1, 4'd0, 32'h7FFF_FFFF, 32'd1, "R8", 0, 0, 8'd1, 8'd0, 8'd0);
        drive("R4", 1, 4'd1, 32'd3, 32'd5, "R8", 0, 0, 8'd2, 8'd0, 8'd0);
        drive("R4", 1, 4'd1, 32'h8000_0000, 32'd1, "R9", 1, 0, 8'd1, 8'd3, 8'd2);
        drive("R2", 1, 4'd8, 32'd10, 32'd10, "R9", 1, 0, 8'd2, 8'd3, 8'd3);
        drive("R5", 1, 4'd2, 32'h0001_0000, 32'h0001_0000, "R9", 1, 0, 8'd0, 8'd4, 8'd1);
        drive("R5", 1, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9", 1, 0, 8'd0, 8'd1, 8'd4);
        drive("R5", 1, 4'd2, 32'h4000_0000, 32'd2, "R9", 1, 0, 8'd0, 8'd1, 8'd5);
        drive("R6", 1, 4'd3, 32'hF0F0_1234, 32'h0FF0_FFFF, "R9", 1, 0, 8'd1, 8'd2, 8'd6);
        drive("R6", 1, 4'd4, 32'h1200_0000, 32'h0000_0034, "R9", 1, 0, 8'd1, 8'd2, 8'd7);
        drive("R6", 1, 4'd5, 32'hAAAA_5555, 32'hAAAA_5555, "R9", 1, 0, 8'd6, 8'd5, 8'd7);
        drive("R1", 1, 4'd6, 32'd1, 32'h0000_0023, "R8", 0, 1, 8'd6, 8'd0, 8'd0);
        drive("R1", 1, 4'd7, 32'h8000_0000, 32'd31, "R8", 0, 0, 8'd5, 8'd0, 8'd0);
        drive("R2", 1, 4'd9, 32'd1, 32'd2, "R10", 0, 0, 8'd7, 8'd200, 8'd99);
        drive("R7", 0, 4'd1, 32'd0, 32'd1, "R10", 1, 0, 8'd0, 8'd9, 8'd1);
        drive("R7", 1, 4'd15, 32'd0, 32'd1, "R11", 1, 0, 8'd7, 8'd0, 8'd0);
        drive("R1", 1, 4'd1, 32'd9, 32'd9, "R11", 1, 0, 8'd0, 8'd1, 8'd0);
        drive("R1", 0, 4'd0, 32'd1, 32'd1, "R11", 1, 0, 8'd0, 8'd1, 8'd8);
        drive("R1", 0, 4'd0, 32'd0, 32'd0, "R10", 0, 0, 8'd255, 8'd0, 8'd0);
        // R7 reset wins over a valid add in the same cycle
        drive("R7", 1, 4'd0, 32'hFFFF_FFFF, 32'd2, "R8", 0, 0, 8'd0, 8'd0, 8'd0, 1);
        drive("R7", 0, 4'd0, 32'd0, 32'd0, "R8", 0, 1, 8'd4, 8'd0, 8'd0);
        drive("R3", 1, 4'd0, 32'h0000_FFFF, 32'd1, "R9", 1, 0, 8'd5, 8'd6, 8'd2);
        drive("R3", 0, 4'd0, 32'd0, 32'd0, "R9", 1, 0, 8'd5, 8'd6, 8'd3);
        drive("R1", 0, 4'd0, 32'd0, 32'd0, "R8", 0, 0, 8'd0, 8'd0, 8'd0);
        @(posedge clk);
        @(negedge clk);
        wait (sbq.size() == 0);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule